// File: doc/BRIEF.md
# SDRAM Bank Activate Timing Tracker

The tracker watches the command pins of an SDRAM channel and keeps, for each bank, whether a row is open, which row that is, and whether enough clock cycles have passed since the row was opened for a column command (read or write) to be legal. A controller or a protocol monitor uses the per-bank ready flags to schedule column commands. The two sticky error flags report rule violations.

The activate-to-column delay is given as a time in picoseconds together with the clock period, and the block turns it into a whole number of cycles by rounding up. Each bank runs its own countdown, so banks opened in different cycles become ready in different cycles. A precharge closes one bank, or every bank when address bit 10 is high. An activate to a bank that is already open, or a column command to a bank that is not yet ready, sets a sticky error flag.

Top module: `bank_act_tracker`

## Requirements
- R1: While and after reset, every bank is idle and not ready, every open-row record is zero, and both error flags are low.
- R2: Commands are decoded only when cs_n is low, from {ras_n,cas_n,we_n}: 011 = activate, 101 = read, 100 = write, 010 = precharge. With cs_n high, or with any other pin pattern (for example 001 refresh or 000 mode set), no bank state and no error flag changes.
- R3: An activate to an idle bank `ba` makes that bank active from the next cycle, and its open-row output (bits ba*ROW_W upward of open_row) holds the addr value of the activate cycle.
- R4: The delay in cycles is N = ceil(T_RCD_PS / T_CLK_PS), with a minimum of 1, which is 3 for the defaults. For an activate in cycle k, bank_ready of that bank is low in cycles k+1 to k+N-1 and high from cycle k+N while the bank stays open.
- R5: Each bank counts its delay on its own; an activate to one bank does not change the active, ready or row state of any other bank.
- R6: A precharge with addr[10] low closes bank `ba` only; with addr[10] high it closes every bank. A closed bank is inactive, not ready, and its row output is zero from the next cycle.
- R7: An activate to a bank that is already active sets err_act from the next cycle and leaves that bank's row, active and ready state unchanged.
- R8: A read or write to a bank whose ready flag is low in that cycle (idle, or still counting) sets err_col from the next cycle.
- R9: A read or write to a ready bank raises no error and changes no bank state.
- R10: err_act and err_col, once set, stay high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank number of the command |
| addr | input | 13 | Row address on activate; bit 10 selects all banks on precharge |
| bank_active | output | 4 | One bit per bank, high while a row is open |
| bank_ready | output | 4 | One bit per bank, high when a column command is legal |
| open_row | output | 52 | Open row of each bank, bank b in bits b*13 upward |
| err_act | output | 1 | Sticky: activate to an open bank |
| err_col | output | 1 | Sticky: column command to a bank not ready |

## Verification
The bench aims at the cycle where ready rises, reading each bank in the cycle N after its activate. A design that counted one cycle too many would flag that legal read, and one that counted one too few would show ready a cycle early. It opens two banks in adjacent cycles to catch a shared counter, which would make both ready together. It sends an activate to an open bank and looks at that bank's row afterwards, since a design that reloads on the second activate would overwrite the row and restart the count. It also sends pin patterns that are not tracked commands, and precharges with and without the all-banks bit, to catch decodes that treat refresh or mode set as an activate or close the wrong banks.

// File: rtl/bat_pkg.sv
package bat_pkg;

    typedef enum logic [2:0] {
        CMD_NONE = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_PRE  = 3'd4
    } bat_cmd_e;

    // Whole cycles covering a time span, rounded up.
    function automatic int unsigned bat_ceil_div(input int unsigned num,
                                                 input int unsigned den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/bat_cmd_decode.sv
module bat_cmd_decode
    import bat_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BA_W      = 2
) (
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [BA_W-1:0]      ba,
    input  logic                 ap_flag,
    output bat_cmd_e             cmd,
    output logic [NUM_BANKS-1:0] sel,
    output logic                 pre_all
);

    always_comb begin
        cmd = CMD_NONE;
        if (!cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b010:  cmd = CMD_PRE;
                default: cmd = CMD_NONE;
            endcase
        end
    end

    always_comb begin
        pre_all = (cmd == CMD_PRE) && ap_flag;
        for (int i = 0; i < NUM_BANKS; i++) begin
            sel[i] = (cmd != CMD_NONE) && (ba == BA_W'(i));
        end
    end

endmodule

// File: rtl/bat_bank_slot.sv
module bat_bank_slot
    import bat_pkg::*;
#(
    parameter int ROW_W   = 13,
    parameter int RCD_CYC = 3,
    parameter int CNT_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bat_cmd_e         cmd,
    input  logic             hit,
    input  logic             pre_all,
    input  logic [ROW_W-1:0] row_in,
    output logic             active,
    output logic             ready,
    output logic [ROW_W-1:0] row
);

    localparam logic [CNT_W-1:0] LOAD = CNT_W'(RCD_CYC - 1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
        logic [ROW_W-1:0] row;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.active && (s_q.cnt != '0)) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
        if ((cmd == CMD_ACT) && hit && !s_q.active) begin
            s_d.active = 1'b1;
            s_d.row    = row_in;
            s_d.cnt    = LOAD;
        end
        if ((cmd == CMD_PRE) && (hit || pre_all)) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign active = s_q.active;
    assign ready  = s_q.active && (s_q.cnt == '0);
    assign row    = s_q.row;

endmodule

// File: rtl/bat_err_track.sv
module bat_err_track
    import bat_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  bat_cmd_e             cmd,
    input  logic [NUM_BANKS-1:0] sel,
    input  logic [NUM_BANKS-1:0] active,
    input  logic [NUM_BANKS-1:0] ready,
    output logic                 err_act,
    output logic                 err_col
);

    typedef struct packed {
        logic act;
        logic col;
    } err_t;

    err_t e_d, e_q;

    logic act_bad, col_bad;

    always_comb begin
        act_bad = (cmd == CMD_ACT) && |(sel & active);
        col_bad = ((cmd == CMD_RD) || (cmd == CMD_WR)) && !(|(sel & ready));
        e_d     = e_q;
        if (act_bad) e_d.act = 1'b1;
        if (col_bad) e_d.col = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q <= '0;
        end else begin
            e_q <= e_d;
        end
    end

    assign err_act = e_q.act;
    assign err_col = e_q.col;

endmodule

// File: rtl/bank_act_tracker.sv
module bank_act_tracker
    import bat_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int AP_BIT    = 10,
    parameter int T_RCD_PS  = 18000,
    parameter int T_CLK_PS  = 7500
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs_n,
    input  logic                       ras_n,
    input  logic                       cas_n,
    input  logic                       we_n,
    input  logic [$clog2(NUM_BANKS)-1:0] ba,
    input  logic [ROW_W-1:0]           addr,
    output logic [NUM_BANKS-1:0]       bank_active,
    output logic [NUM_BANKS-1:0]       bank_ready,
    output logic [NUM_BANKS*ROW_W-1:0] open_row,
    output logic                       err_act,
    output logic                       err_col
);

    localparam int BA_W    = $clog2(NUM_BANKS);
    localparam int RCD_RAW = int'(bat_ceil_div(T_RCD_PS, T_CLK_PS));
    localparam int RCD_CYC = (RCD_RAW < 1) ? 1 : RCD_RAW;
    localparam int CNT_W   = (RCD_CYC < 2) ? 1 : $clog2(RCD_CYC);

    bat_cmd_e             cmd;
    logic [NUM_BANKS-1:0] sel;
    logic                 pre_all;

    bat_cmd_decode #(
        .NUM_BANKS (NUM_BANKS),
        .BA_W      (BA_W)
    ) u_dec (
        .cs_n    (cs_n),
        .ras_n   (ras_n),
        .cas_n   (cas_n),
        .we_n    (we_n),
        .ba      (ba),
        .ap_flag (addr[AP_BIT]),
        .cmd     (cmd),
        .sel     (sel),
        .pre_all (pre_all)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        bat_bank_slot #(
            .ROW_W   (ROW_W),
            .RCD_CYC (RCD_CYC),
            .CNT_W   (CNT_W)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .cmd     (cmd),
            .hit     (sel[g]),
            .pre_all (pre_all),
            .row_in  (addr),
            .active  (bank_active[g]),
            .ready   (bank_ready[g]),
            .row     (open_row[g*ROW_W +: ROW_W])
        );
    end

    bat_err_track #(
        .NUM_BANKS (NUM_BANKS)
    ) u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .sel     (sel),
        .active  (bank_active),
        .ready   (bank_ready),
        .err_act (err_act),
        .err_col (err_col)
    );

endmodule

// File: rtl/bat_checker.sv
module bat_checker #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int AP_BIT    = 10,
    parameter int RCD_CYC   = 3
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cs_n,
    input logic                         ras_n,
    input logic                         cas_n,
    input logic                         we_n,
    input logic [$clog2(NUM_BANKS)-1:0] ba,
    input logic [ROW_W-1:0]             addr,
    input logic [NUM_BANKS-1:0]         bank_active,
    input logic [NUM_BANKS-1:0]         bank_ready,
    input logic [NUM_BANKS*ROW_W-1:0]   open_row,
    input logic                         err_act,
    input logic                         err_col
);

    localparam int BA_W = $clog2(NUM_BANKS);

    logic is_act, is_pre, is_col;
    assign is_act = !cs_n && !ras_n &&  cas_n &&  we_n;
    assign is_pre = !cs_n && !ras_n &&  cas_n && !we_n;
    assign is_col = !cs_n &&  ras_n && !cas_n;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
        a_r3_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
            (is_act && ba == BA_W'(b) && !bank_active[b]) |=>
            (bank_active[b] && open_row[b*ROW_W +: ROW_W] == $past(addr)));

        a_r7_busy_act_keeps_row: assert property (@(posedge clk) disable iff (!rst_n)
            (is_act && ba == BA_W'(b) && bank_active[b]) |=>
            (err_act && bank_active[b] && $stable(open_row[b*ROW_W +: ROW_W])));

        a_r6_pre_closes: assert property (@(posedge clk) disable iff (!rst_n)
            (is_pre && (ba == BA_W'(b) || addr[AP_BIT])) |=>
            (!bank_active[b] && !bank_ready[b] && open_row[b*ROW_W +: ROW_W] == '0));

        if (RCD_CYC > 1) begin : g_wait
            a_r4_not_ready_early: assert property (@(posedge clk) disable iff (!rst_n)
                (is_act && ba == BA_W'(b) && !bank_active[b]) |=> !bank_ready[b]);
        end
    end

    a_r8_early_col: assert property (@(posedge clk) disable iff (!rst_n)
        (is_col && !bank_ready[ba]) |=> err_col);

    a_r9_legal_col_still: assert property (@(posedge clk) disable iff (!rst_n)
        (is_col && bank_ready[ba]) |=> ($stable(bank_active) && $stable(open_row)));

    a_r2_deselect_still: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> ($stable(bank_active) && $stable(open_row)));

    a_r10_act_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_act |=> err_act);

    a_r10_col_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_col |=> err_col);

endmodule

bind bank_act_tracker bat_checker #(
    .NUM_BANKS (NUM_BANKS),
    .ROW_W     (ROW_W),
    .AP_BIT    (AP_BIT),
    .RCD_CYC   (RCD_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .ras_n       (ras_n),
    .cas_n       (cas_n),
    .we_n        (we_n),
    .ba          (ba),
    .addr        (addr),
    .bank_active (bank_active),
    .bank_ready  (bank_ready),
    .open_row    (open_row),
    .err_act     (err_act),
    .err_col     (err_col)
);

// File: tb/bank_act_tracker_tb.sv
module bank_act_tracker_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NB         = 4;
    localparam int RW         = 13;
    localparam int EXP_RCD    = 3;   // ceil(18000 / 7500), R4

    localparam int K_NOP = 0, K_ACT = 1, K_RD = 2, K_WR = 3, K_PRE = 4,
                   K_PALL = 5, K_DESEL = 6, K_REF = 7, K_MRS = 8;

    typedef struct packed {
        logic [NB-1:0]    act;
        logic [NB-1:0]    rdy;
        logic [NB*RW-1:0] rows;
        logic             ea;
        logic             ec;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = '0;
    logic [RW-1:0] addr = '0;
    logic [NB-1:0] bank_active, bank_ready;
    logic [NB*RW-1:0] open_row;
    logic err_act, err_col;

    bank_act_tracker #(
        .NUM_BANKS (NB),
        .ROW_W     (RW),
        .AP_BIT    (10),
        .T_RCD_PS  (18000),
        .T_CLK_PS  (7500)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .ras_n       (ras_n),
        .cas_n       (cas_n),
        .we_n        (we_n),
        .ba          (ba),
        .addr        (addr),
        .bank_active (bank_active),
        .bank_ready  (bank_ready),
        .open_row    (open_row),
        .err_act     (err_act),
        .err_col     (err_col)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    exp_t  q_exp[$];
    string q_tag[$];

    // Reference state of the bench
    logic          m_act[NB];
    logic [RW-1:0] m_row[NB];
    int            m_at[NB];
    logic          m_ea, m_ec;
    int            mcyc;

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [63:0] got, input logic [63:0] want);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, got, want);
        end
    endtask

    task automatic compare(input exp_t e, input string tag);
        chk(bank_active == e.act, tag, "bank_active", 64'(bank_active), 64'(e.act));
        chk(bank_ready == e.rdy, tag, "bank_ready", 64'(bank_ready), 64'(e.rdy));
        chk(open_row == e.rows, tag, "open_row", 64'(open_row), 64'(e.rows));
        chk(err_act == e.ea, tag, "err_act", 64'(err_act), 64'(e.ea));
        chk(err_col == e.ec, tag, "err_col", 64'(err_col), 64'(e.ec));
    endtask

    // Monitor: pops one expected item per cycle, sampled after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_exp.size() > 0) begin
                exp_t e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                compare(e, t);
            end
        end
    end

    function automatic logic bank_rdy(input int b);
        return m_act[b] && ((mcyc - m_at[b]) >= EXP_RCD);
    endfunction

    task automatic model_clear();
        for (int b = 0; b < NB; b++) begin
            m_act[b] = 1'b0;
            m_row[b] = '0;
            m_at[b]  = 0;
        end
        m_ea = 1'b0;
        m_ec = 1'b0;
        mcyc = 0;
    endtask

    // Driver: one command per cycle, expectation pushed for the next cycle
    task automatic step(input int kind, input int b, input logic [RW-1:0] a,
                        input string tag);
        exp_t e;
        @(negedge clk);
        ba   = 2'(b);
        addr = a;
        case (kind)
            K_ACT:   {cs_n, ras_n, cas_n, we_n} = 4'b0011;
            K_RD:    {cs_n, ras_n, cas_n, we_n} = 4'b0101;
            K_WR:    {cs_n, ras_n, cas_n, we_n} = 4'b0100;
            K_PRE:   begin {cs_n, ras_n, cas_n, we_n} = 4'b0010; addr[10] = 1'b0; end
            K_PALL:  begin {cs_n, ras_n, cas_n, we_n} = 4'b0010; addr[10] = 1'b1; end
            K_DESEL: {cs_n, ras_n, cas_n, we_n} = 4'b1011;
            K_REF:   {cs_n, ras_n, cas_n, we_n} = 4'b0001;
            K_MRS:   {cs_n, ras_n, cas_n, we_n} = 4'b0000;
            default: {cs_n, ras_n, cas_n, we_n} = 4'b0111;
        endcase
        case (kind)
            K_ACT: begin
                if (m_act[b]) m_ea = 1'b1;
                else begin
                    m_act[b] = 1'b1;
                    m_row[b] = a;
                    m_at[b]  = mcyc;
                end
            end
            K_RD, K_WR: if (!bank_rdy(b)) m_ec = 1'b1;
            K_PRE: begin m_act[b] = 1'b0; m_row[b] = '0; end
            K_PALL: for (int i = 0; i < NB; i++) begin
                m_act[i] = 1'b0;
                m_row[i] = '0;
            end
            default: ;
        endcase
        mcyc++;
        for (int i = 0; i < NB; i++) begin
            e.act[i] = m_act[i];
            e.rdy[i] = bank_rdy(i);
            e.rows[i*RW +: RW] = m_row[i];
        end
        e.ea = m_ea;
        e.ec = m_ec;
        q_exp.push_back(e);
        q_tag.push_back(tag);
    endtask

    task automatic reset_dut(input string tag);
        while (q_exp.size() != 0) @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        {cs_n, ras_n, cas_n, we_n} = 4'b1111;
        repeat (3) @(negedge clk);
        chk(bank_active == '0, tag, "reset bank_active", 64'(bank_active), 64'h0);
        chk(bank_ready == '0, tag, "reset bank_ready", 64'(bank_ready), 64'h0);
        chk(open_row == '0, tag, "reset open_row", 64'(open_row), 64'h0);
        chk({err_act, err_col} == 2'b00, tag, "reset errors", 64'({err_act, err_col}), 64'h0);
        rst_n = 1'b1;
        model_clear();
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=expired expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        model_clear();
        reset_dut("R1");

        step(K_NOP, 0, '0, "R2 nop");
        step(K_NOP, 1, '0, "R2 nop");

        // Two banks opened in adjacent cycles: ready must rise per bank
        step(K_ACT, 0, 13'h0AB, "R3 open b0");
        step(K_ACT, 2, 13'h1FFF, "R5 open b2");
        step(K_NOP, 0, '0, "R4 count");
        step(K_RD, 0, '0, "R9 read b0 at N");
        step(K_WR, 2, '0, "R9 write b2 at N");

        // Patterns that must not act
        step(K_DESEL, 1, 13'h0123, "R2 deselect");
        step(K_REF, 1, 13'h0456, "R2 refresh pattern");
        step(K_MRS, 3, 13'h0033, "R2 mode pattern");

        // Single-bank precharge and reopen
        step(K_PRE, 0, 13'h0400, "R6 pre b0");
        step(K_ACT, 0, 13'h0055, "R3 reopen b0");
        step(K_NOP, 0, '0, "R4 count b0");
        step(K_NOP, 0, '0, "R4 count b0");
        step(K_NOP, 0, '0, "R4 ready b0");

        // Activate to an open bank
        step(K_ACT, 2, 13'h0777, "R7 busy act b2");
        step(K_NOP, 0, '0, "R10 hold");
        step(K_RD, 2, '0, "R9 read b2");
        step(K_NOP, 0, '0, "R10 hold");

        // All-bank precharge
        step(K_PALL, 1, '0, "R6 pre all");
        step(K_NOP, 0, '0, "R6 closed");

        reset_dut("R1 second");
        step(K_RD, 1, '0, "R8 read idle b1");
        step(K_NOP, 0, '0, "R10 hold col");

        reset_dut("R1 third");
        step(K_ACT, 3, 13'h0100, "R3 open b3");
        step(K_NOP, 0, '0, "R4 wait");
        step(K_WR, 3, '0, "R8 early write b3");
        step(K_NOP, 0, '0, "R10 hold col");
        step(K_PRE, 3, '0, "R6 pre b3");
        step(K_NOP, 0, '0, "R6 closed b3");

        while (q_exp.size() != 0) @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule